// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widener

This block turns a 16-bit binary floating-point value into a 32-bit single-precision value. The conversion never loses information, so the block has no rounding logic. A mode input picks how the top exponent code of the half-precision input is read. In standard mode that code means infinity or NaN. In extended-range mode it is one more ordinary binade of finite numbers, so the largest magnitude doubles and there are no special values.

Half-precision subnormals become normal single-precision numbers. A priority encoder finds the leading one of the 10-bit fraction, and the fraction is shifted until the hidden bit sits in the implied position. In standard mode a NaN comes out as a quiet NaN with its payload kept. A flag reports when the input NaN was signalling. The result and the flag are registered, so they appear one clock after the operand is presented.

Top module: `hfw_widen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `word_out` and `invalid_out` are 0 after that edge.
- R2: The result for an operand sampled at a rising edge appears on the outputs right after that edge, with one cycle of latency. Bit 31 of the result always equals bit 15 of the operand.
- R3: An operand whose bits 14:0 are all zero gives a single-precision zero (bits 30:0 zero) with the operand's sign, in either mode.
- R4: For an exponent field (bits 14:10) in 1..30, the result exponent (bits 30:23) is the field plus 112. The result fraction (bits 22:0) is the operand fraction (bits 9:0) followed by 13 zero bits.
- R5: For exponent field 0 and a nonzero fraction f, let p be the bit index of the highest set bit of f. The result exponent is 103 + p. The result fraction holds the bits of f below bit p, left-aligned, with all other bits zero.
- R6: In standard mode (`alt_mode`=0), exponent field 31 with a zero fraction gives an infinity: bits 30:0 equal 0x7F800000.
- R7: In standard mode, exponent field 31 with a nonzero fraction gives result exponent 0xFF. Result bit 22 is forced to 1, result bits 21:13 copy operand bits 8:0, and result bits 12:0 are zero.
- R8: `invalid_out` is 1 exactly when the operand was a standard-mode NaN with operand bit 9 (the quiet bit) clear. It is 0 in all other cases.
- R9: In extended-range mode (`alt_mode`=1), exponent field 31 is finite. The result exponent is 143, the fraction follows R4, and `invalid_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| half_in | input | 16 | Half-precision operand |
| alt_mode | input | 1 | 0: standard encoding; 1: extended-range encoding with no special values |
| word_out | output | 32 | Single-precision result, registered |
| invalid_out | output | 1 | Signalling-NaN flag, registered |

## Verification
The mode decode and the NaN handling can both act on the same cycle, because the encoding that is a signalling NaN in one mode is a finite number in the other. The bench applies the same exponent-31 operand on back-to-back cycles with only `alt_mode` toggled. It checks that the flag and the quieted payload appear only in the standard-mode cycle, and that the neighbouring cycle gives exponent 143 with no flag. An exhaustive sweep in both modes then applies a new operand every clock, so each result is checked against the operand driven one cycle earlier.

// File: rtl/hfw_pkg.sv
package hfw_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } hcls_e;

endpackage

// File: rtl/hfw_lzc.sv
module hfw_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] lz,
  output logic          all_zero
);

  logic [CW-1:0] top_idx;

  // Scanning upward lets the highest set bit win.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) top_idx = CW'(i);
    end
  end

  assign all_zero = (vec == '0);
  assign lz       = CW'(W - 1) - top_idx;

endmodule

// File: rtl/hfw_classify.sv
module hfw_classify
  import hfw_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10,
  localparam int HW = 1 + HE + HF
) (
  input  logic [HW-1:0] operand,
  input  logic          alt_mode,
  output logic          sign,
  output logic [HE-1:0] exp_f,
  output logic [HF-1:0] frac_f,
  output hcls_e         cls
);

  assign sign   = operand[HW-1];
  assign exp_f  = operand[HW-2:HF];
  assign frac_f = operand[HF-1:0];

  always_comb begin
    if (exp_f == '0) begin
      cls = (frac_f == '0) ? CLS_ZERO : CLS_SUB;
    end else if (exp_f == '1 && !alt_mode) begin
      cls = (frac_f == '0) ? CLS_INF : CLS_NAN;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/hfw_assemble.sv
module hfw_assemble
  import hfw_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23,
  localparam int CW      = $clog2(HF),
  localparam int SW      = 1 + SE + SF,
  localparam int PAD     = SF - HF,
  localparam int EXP_OFF = ((1 << (SE - 1)) - 1) - ((1 << (HE - 1)) - 1)
) (
  input  logic          sign,
  input  logic [HE-1:0] exp_f,
  input  logic [HF-1:0] frac_f,
  input  hcls_e         cls,
  input  logic [CW-1:0] lz,
  output logic [SW-1:0] word,
  output logic          invalid
);

  logic [HF-1:0] sub_frac;
  logic [SE-1:0] sub_exp;
  logic [SE-1:0] norm_exp;

  // Shifting one place past the leading one drops the hidden bit.
  assign sub_frac = frac_f << (lz + 1'b1);
  assign sub_exp  = SE'(EXP_OFF) - SE'(lz);
  assign norm_exp = SE'(exp_f) + SE'(EXP_OFF);

  always_comb begin
    invalid = 1'b0;
    unique case (cls)
      CLS_ZERO: word = {sign, {(SW-1){1'b0}}};
      CLS_SUB:  word = {sign, sub_exp, sub_frac, {PAD{1'b0}}};
      CLS_INF:  word = {sign, {SE{1'b1}}, {SF{1'b0}}};
      CLS_NAN: begin
        word    = {sign, {SE{1'b1}}, 1'b1, frac_f[HF-2:0], {PAD{1'b0}}};
        invalid = ~frac_f[HF-1];
      end
      default:  word = {sign, norm_exp, frac_f, {PAD{1'b0}}};
    endcase
  end

endmodule

// File: rtl/hfw_widen.sv
module hfw_widen
  import hfw_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23,
  localparam int HW = 1 + HE + HF,
  localparam int SW = 1 + SE + SF,
  localparam int CW = $clog2(HF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] half_in,
  input  logic          alt_mode,
  output logic [SW-1:0] word_out,
  output logic          invalid_out
);

  logic          sign;
  logic [HE-1:0] exp_f;
  logic [HF-1:0] frac_f;
  hcls_e         cls;
  logic [CW-1:0] lz;
  logic          frac_zero;
  logic [SW-1:0] word_nxt;
  logic          inv_nxt;

  hfw_classify #(.HE(HE), .HF(HF)) i_classify (
    .operand  (half_in),
    .alt_mode (alt_mode),
    .sign     (sign),
    .exp_f    (exp_f),
    .frac_f   (frac_f),
    .cls      (cls)
  );

  hfw_lzc #(.W(HF)) i_lzc (
    .vec      (frac_f),
    .lz       (lz),
    .all_zero (frac_zero)
  );

  hfw_assemble #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) i_assemble (
    .sign    (sign),
    .exp_f   (exp_f),
    .frac_f  (frac_f),
    .cls     (cls),
    .lz      (lz),
    .word    (word_nxt),
    .invalid (inv_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out    <= '0;
      invalid_out <= 1'b0;
    end else begin
      word_out    <= word_nxt;
      invalid_out <= inv_nxt & ~frac_zero;
    end
  end

endmodule

// File: rtl/hfw_widen_chk.sv
module hfw_widen_chk #(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23,
  localparam int HW = 1 + HE + HF,
  localparam int SW = 1 + SE + SF,
  localparam int EXP_OFF = ((1 << (SE - 1)) - 1) - ((1 << (HE - 1)) - 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] half_in,
  input logic          alt_mode,
  input logic [SW-1:0] word_out,
  input logic          invalid_out
);

  logic [HE-1:0] in_exp;
  logic [HF-1:0] in_frac;
  assign in_exp  = half_in[HW-2:HF];
  assign in_frac = half_in[HF-1:0];

  a_r1_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (word_out == '0 && !invalid_out));

  a_r2_sign_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> word_out[SW-1] == $past(half_in[HW-1]));

  a_r3_zero: assert property (@(posedge clk) disable iff (rst)
    (half_in[HW-2:0] == '0) |=> (word_out[SW-2:0] == '0 && !invalid_out));

  a_r4_normal_bias: assert property (@(posedge clk) disable iff (rst)
    (in_exp != '0 && in_exp != '1)
    |=> (word_out[SW-2:SF] == SE'($past(in_exp)) + SE'(EXP_OFF)
         && word_out[SF-1:SF-HF] == $past(in_frac)));

  a_r6_infinity: assert property (@(posedge clk) disable iff (rst)
    (!alt_mode && in_exp == '1 && in_frac == '0)
    |=> (word_out[SW-2:SF] == '1 && word_out[SF-1:0] == '0));

  a_r8_flag_source: assert property (@(posedge clk) disable iff (rst)
    invalid_out |-> (word_out[SW-2:SF] == '1 && word_out[SF-1]));

  a_r9_alt_top_binade: assert property (@(posedge clk) disable iff (rst)
    (alt_mode && in_exp == '1)
    |=> (word_out[SW-2:SF] == SE'((1 << HE) - 1 + EXP_OFF) && !invalid_out));

endmodule

bind hfw_widen hfw_widen_chk #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .half_in     (half_in),
  .alt_mode    (alt_mode),
  .word_out    (word_out),
  .invalid_out (invalid_out)
);

// File: tb/test_hfw_widen.sv
module test_hfw_widen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] half_in = '0;
  logic        alt_mode = 1'b0;
  logic [31:0] word_out;
  logic        invalid_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hfw_widen i_hfw_widen (
    .clk         (clk),
    .rst         (rst),
    .half_in     (half_in),
    .alt_mode    (alt_mode),
    .word_out    (word_out),
    .invalid_out (invalid_out)
  );

  // {alt, operand, expected word, expected flag}
  localparam int NV = 20;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'h0000, 32'h0000_0000, 1'b0},  // R3
    {1'b0, 16'h8000, 32'h8000_0000, 1'b0},  // R3
    {1'b0, 16'h3C00, 32'h3F80_0000, 1'b0},  // R4
    {1'b0, 16'hC000, 32'hC000_0000, 1'b0},  // R4 R2
    {1'b0, 16'h7BFF, 32'h477F_E000, 1'b0},  // R4
    {1'b0, 16'h0400, 32'h3880_0000, 1'b0},  // R4
    {1'b0, 16'h0001, 32'h3380_0000, 1'b0},  // R5
    {1'b0, 16'h0200, 32'h3800_0000, 1'b0},  // R5
    {1'b0, 16'h03FF, 32'h387F_C000, 1'b0},  // R5
    {1'b1, 16'h8001, 32'hB380_0000, 1'b0},  // R5
    {1'b0, 16'h7C00, 32'h7F80_0000, 1'b0},  // R6
    {1'b0, 16'hFC00, 32'hFF80_0000, 1'b0},  // R6
    {1'b0, 16'h7E00, 32'h7FC0_0000, 1'b0},  // R7
    {1'b0, 16'h7C01, 32'h7FC0_2000, 1'b1},  // R7 R8
    {1'b1, 16'h7C01, 32'h4780_2000, 1'b0},  // R9
    {1'b0, 16'hFD00, 32'hFFE0_0000, 1'b1},  // R8
    {1'b1, 16'h7C00, 32'h4780_0000, 1'b0},  // R9
    {1'b1, 16'h7FFF, 32'h47FF_E000, 1'b0},  // R9
    {1'b1, 16'hFC01, 32'hC780_2000, 1'b0},  // R9
    {1'b1, 16'h3C00, 32'h3F80_0000, 1'b0}   // R4
  };

  function automatic logic [32:0] ref_widen(input logic [15:0] h, input logic alt);
    logic       s;
    logic [4:0] e;
    logic [9:0] f;
    int         p;
    logic [22:0] m;
    s = h[15];
    e = h[14:10];
    f = h[9:0];
    if (e == 5'd0 && f == 10'd0) return {s, 31'd0, 1'b0};
    if (e == 5'd0) begin
      p = 0;
      for (int i = 0; i < 10; i++) if (f[i]) p = i;
      m = 23'({f, 13'd0} << (10 - p));
      return {s, 8'(103 + p), m, 1'b0};
    end
    if (e == 5'd31 && !alt) begin
      if (f == 10'd0) return {s, 8'hFF, 23'd0, 1'b0};
      return {s, 8'hFF, 1'b1, f[8:0], 13'd0, ~f[9]};
    end
    return {s, 8'(e) + 8'd112, f, 13'd0, 1'b0};
  endfunction

  task automatic judge(input string req, input logic [31:0] ew, input logic ei);
    checks++;
    if (word_out !== ew || invalid_out !== ei) begin
      errors++;
      $display("FAIL %s: got word=%h inv=%b, expected word=%h inv=%b",
               req, word_out, invalid_out, ew, ei);
    end
  endtask

  initial begin
    logic [32:0] pend;
    string       pend_req;
    repeat (3) @(negedge clk);
    judge("R1", 32'h0, 1'b0);

    @(negedge clk);
    rst = 1'b0;
    pend_req = "";
    for (int k = 0; k < NV; k++) begin
      alt_mode = VEC[k][49];
      half_in  = VEC[k][48:33];
      @(negedge clk);
      judge($sformatf("R2 vector %0d", k), VEC[k][32:1], VEC[k][0]);
    end

    // Exhaustive sweep, one operand per cycle, checked one cycle later.
    pend = '0;
    for (int md = 0; md < 2; md++) begin
      for (int v = 0; v < 65536; v++) begin
        alt_mode = 1'(md);
        half_in  = 16'(v);
        @(negedge clk);
        pend = ref_widen(16'(v), 1'(md));
        judge(md == 0 ? "R5 sweep standard" : "R9 sweep extended",
              pend[32:1], pend[0]);
      end
    end

    // Reset in mid-stream clears a flagged result.
    alt_mode = 1'b0;
    half_in  = 16'h7C01;
    @(negedge clk);
    judge("R8", 32'h7FC0_2000, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    judge("R1", 32'h0, 1'b0);
    rst = 1'b0;
    half_in = 16'h8000;
    @(negedge clk);
    judge("R3", 32'h8000_0000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule